// File: doc/BRIEF.md
# Dual-Tone Keypad Signal Synthesizer with Timed Bursts

This block turns a 4-bit key code into a digital dual-tone sample stream. A row oscillator and a column oscillator each run a programmable divider on the reference clock of 3.579545 MHz. Each divider wrap advances a 5-bit phase counter. The phase counter addresses a 32-step sine table. The column sample is raised by a 5/4 ratio, which is about 2 dB, and added to the row sample to form a signed output word. A downstream DAC and filter turn that word into the analog signal.

The block plays tones in two ways. With timed bursts off, a code write loads the tone at once, and the tone plays for as long as the enable input is high. With timed bursts on, a code write starts a burst of the tone, followed by a silent pause of the same length. A one-cycle ready pulse then marks that the next code may be written. The call-progress input doubles both the burst and the pause. Single-tone mode outputs only the row tone or only the column tone.

Top module: `dtmf_burst_gen`

## Requirements
- R1: Each key code selects one row and one column frequency. Codes 1/2/3 give 697 Hz with 1209/1336/1477 Hz. Codes 4/5/6 give 770 Hz, and codes 7/8/9 give 852 Hz, each with the same three column tones. Code 10 gives 941+1336 Hz, code 11 gives 941+1209 Hz and code 12 gives 941+1477 Hz. Codes 13/14/15 give 697/770/852 Hz with 1633 Hz. Code 0 gives 941+1633 Hz.
- R2: A tone lasts 32*T clock cycles, with T = floor((3579545+16f)/(32f)). The row terminal counts are 160/145/131/119 for 697/770/852/941 Hz. The column terminal counts are 93/84/76/69 for 1209/1336/1477/1633 Hz. The row sample swings exactly between +100 and -100. The column sample is floor(5*s/4) of the same table and swings between +125 and -125.
- R3: With singleTone=1, colSel=0 outputs only the row tone and colSel=1 outputs only the column tone.
- R4: With singleTone=0, the output is the sum of both samples. Its peak exceeds 125 in magnitude and never exceeds 225 in magnitude.
- R5: When toneEn is 0, sampleOut is 0 from the next clock edge onward.
- R6: With burstEn=0, a code write loads the tone immediately. The tone plays while toneEn=1, and txReady never pulses.
- R7: With burstEn=1 and no burst running, a code write accepted on edge E starts a burst of L = TICK_DIV*BURST_TICKS cycles, then a silent pause of L cycles. txReady is high for exactly the one cycle after edge E+2L. The output stays silent afterwards until the next write.
- R8: With cpMode=1 at the accepting write, the burst and the pause each last 2L cycles, and txReady follows edge E+4L.
- R9: A code write during a burst or a pause is ignored. It changes neither the running timing nor the code, and it produces no additional ready pulse.
- R10: While rstN is low, sampleOut is 0 and txReady is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominally 3.579545 MHz |
| rstN | input | 1 | Active-low synchronous reset |
| codeIn | input | 4 | Key code to play |
| codeWr | input | 1 | One-cycle strobe that writes codeIn |
| toneEn | input | 1 | Tone output enable |
| burstEn | input | 1 | 1 selects timed burst/pause operation |
| cpMode | input | 1 | 1 doubles burst and pause length |
| singleTone | input | 1 | 1 outputs a single tone |
| colSel | input | 1 | In single-tone mode: 0 row, 1 column |
| sampleOut | output | SAMPLE_W | Signed output sample word |
| txReady | output | 1 | One-cycle pulse after a burst's pause ends |

## Verification
A wrong divider count or a wrong key decode shows up as a tone period on sampleOut that differs from 32*T. This is visible within two tone periods, which is at most about 10k cycles. A fault in the sine table or the column scaling shows up as a wrong peak within one period. A fault in the burst timer moves the txReady pulse or lets tone energy into the pause, and this is visible within 2L or 4L cycles of the write. A write that is wrongly accepted during a burst shows up as an extra or displaced ready pulse.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  localparam int REF_HZ   = 3579545;
  localparam int SEGMENTS = 32;
  localparam int DIV_W    = 8;
  localparam int TONE_W   = 9;

  typedef struct packed {
    logic loadCode;
    logic toneOn;
    logic busy;
  } strobes_t;

  function automatic logic [DIV_W-1:0] termOf(input int hz);
    int tc;
    tc = (REF_HZ + (SEGMENTS / 2) * hz) / (SEGMENTS * hz);
    return DIV_W'(tc);
  endfunction

  function automatic logic [DIV_W-1:0] rowTerm(input logic [1:0] idx);
    case (idx)
      2'd0:    return termOf(697);
      2'd1:    return termOf(770);
      2'd2:    return termOf(852);
      default: return termOf(941);
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] colTerm(input logic [1:0] idx);
    case (idx)
      2'd0:    return termOf(1209);
      2'd1:    return termOf(1336);
      2'd2:    return termOf(1477);
      default: return termOf(1633);
    endcase
  endfunction

  // returns {rowIdx, colIdx}
  function automatic logic [3:0] keyPos(input logic [3:0] code);
    case (code)
      4'd1:    return {2'd0, 2'd0};
      4'd2:    return {2'd0, 2'd1};
      4'd3:    return {2'd0, 2'd2};
      4'd4:    return {2'd1, 2'd0};
      4'd5:    return {2'd1, 2'd1};
      4'd6:    return {2'd1, 2'd2};
      4'd7:    return {2'd2, 2'd0};
      4'd8:    return {2'd2, 2'd1};
      4'd9:    return {2'd2, 2'd2};
      4'd10:   return {2'd3, 2'd1};
      4'd11:   return {2'd3, 2'd0};
      4'd12:   return {2'd3, 2'd2};
      4'd13:   return {2'd0, 2'd3};
      4'd14:   return {2'd1, 2'd3};
      4'd15:   return {2'd2, 2'd3};
      default: return {2'd3, 2'd3};
    endcase
  endfunction

  function automatic logic signed [TONE_W-1:0] quarterSine(input logic [3:0] idx);
    case (idx)
      4'd0:    return 9'sd0;
      4'd1:    return 9'sd20;
      4'd2:    return 9'sd38;
      4'd3:    return 9'sd56;
      4'd4:    return 9'sd71;
      4'd5:    return 9'sd83;
      4'd6:    return 9'sd92;
      4'd7:    return 9'sd98;
      default: return 9'sd100;
    endcase
  endfunction

endpackage

// File: rtl/dtmf_tone_osc.sv
module dtmf_tone_osc
  import dtmf_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     restart,
  input  logic [DIV_W-1:0]         termCnt,
  output logic signed [TONE_W-1:0] sample
);

  logic [DIV_W-1:0] divCnt;
  logic [4:0]       phase;
  logic [3:0]       fwdIdx;
  logic [3:0]       mirIdx;
  logic signed [TONE_W-1:0] mag;

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      divCnt <= '0;
      phase  <= '0;
    end else if (divCnt == termCnt - DIV_W'(1)) begin
      divCnt <= '0;
      phase  <= phase + 5'd1;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_comb begin
    fwdIdx = {1'b0, phase[2:0]};
    mirIdx = 4'd8 - fwdIdx;
    mag    = quarterSine(phase[3] ? mirIdx : fwdIdx);
    sample = phase[4] ? -mag : mag;
  end

endmodule

// File: rtl/dtmf_ctrl.sv
module dtmf_ctrl
  import dtmf_pkg::*;
#(
  parameter int TICK_DIV    = 3580,
  parameter int BURST_TICKS = 51
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] codeIn,
  input  logic       codeWr,
  input  logic       toneEn,
  input  logic       burstEn,
  input  logic       cpMode,
  output strobes_t   strb,
  output logic [3:0] codeLatch,
  output logic       txReady
);

  localparam int PRE_W  = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam int TICK_W = $clog2(2 * BURST_TICKS + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST   = PRE_W'(TICK_DIV - 1);
  localparam logic [TICK_W-1:0] SHORT_LAST = TICK_W'(BURST_TICKS - 1);
  localparam logic [TICK_W-1:0] LONG_LAST  = TICK_W'(2 * BURST_TICKS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_BURST, ST_PAUSE} burstState_t;

  burstState_t       state;
  logic [PRE_W-1:0]  preCnt;
  logic [TICK_W-1:0] tickCnt;
  logic              longSel;
  logic [TICK_W-1:0] lastTick;
  logic              accept;

  always_comb begin
    lastTick      = longSel ? LONG_LAST : SHORT_LAST;
    accept        = codeWr && (!burstEn || state == ST_IDLE);
    strb.loadCode = accept;
    strb.toneOn   = toneEn && (!burstEn || state == ST_BURST);
    strb.busy     = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeLatch <= '0;
    end else if (accept) begin
      codeLatch <= codeIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      preCnt  <= '0;
      tickCnt <= '0;
      longSel <= 1'b0;
      txReady <= 1'b0;
    end else begin
      txReady <= 1'b0;
      if (!burstEn) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (codeWr) begin
              state   <= ST_BURST;
              preCnt  <= '0;
              tickCnt <= '0;
              longSel <= cpMode;
            end
          end
          default: begin
            if (preCnt == PRE_LAST) begin
              preCnt <= '0;
              if (tickCnt == lastTick) begin
                tickCnt <= '0;
                if (state == ST_BURST) begin
                  state <= ST_PAUSE;
                end else begin
                  state   <= ST_IDLE;
                  txReady <= 1'b1;
                end
              end else begin
                tickCnt <= tickCnt + TICK_W'(1);
              end
            end else begin
              preCnt <= preCnt + PRE_W'(1);
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/dtmf_datapath.sv
module dtmf_datapath
  import dtmf_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobes_t                   strb,
  input  logic [3:0]                 codeLatch,
  input  logic                       singleTone,
  input  logic                       colSel,
  output logic signed [SAMPLE_W-1:0] sampleOut
);

  localparam int NUM_OSC = 2;
  localparam int MW      = SAMPLE_W + 3;

  logic [3:0]               pos;
  logic [DIV_W-1:0]         termCnt [NUM_OSC];
  logic signed [TONE_W-1:0] toneSmp [NUM_OSC];
  logic signed [MW-1:0]     rowWide;
  logic signed [MW-1:0]     colWide;
  logic signed [MW-1:0]     colScaled;
  logic signed [MW-1:0]     mixed;

  assign pos = keyPos(codeLatch);

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    if (g == 0) begin : g_row
      assign termCnt[g] = rowTerm(pos[3:2]);
    end else begin : g_col
      assign termCnt[g] = colTerm(pos[1:0]);
    end
    dtmf_tone_osc i_osc (
      .clk    (clk),
      .rstN   (rstN),
      .restart(strb.loadCode),
      .termCnt(termCnt[g]),
      .sample (toneSmp[g])
    );
  end

  always_comb begin
    rowWide   = MW'(toneSmp[0]);
    colWide   = MW'(toneSmp[1]);
    colScaled = ((colWide <<< 2) + colWide) >>> 2;
    if (singleTone) begin
      mixed = colSel ? colScaled : rowWide;
    end else begin
      mixed = rowWide + colScaled;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleOut <= '0;
    end else begin
      sampleOut <= strb.toneOn ? SAMPLE_W'(mixed) : '0;
    end
  end

endmodule

// File: rtl/dtmf_burst_gen.sv
module dtmf_burst_gen
  import dtmf_pkg::*;
#(
  parameter int TICK_DIV    = 3580,
  parameter int BURST_TICKS = 51,
  parameter int SAMPLE_W    = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [3:0]                 codeIn,
  input  logic                       codeWr,
  input  logic                       toneEn,
  input  logic                       burstEn,
  input  logic                       cpMode,
  input  logic                       singleTone,
  input  logic                       colSel,
  output logic signed [SAMPLE_W-1:0] sampleOut,
  output logic                       txReady
);

  strobes_t   strb;
  logic [3:0] codeLatch;

  dtmf_ctrl #(
    .TICK_DIV   (TICK_DIV),
    .BURST_TICKS(BURST_TICKS)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .codeIn   (codeIn),
    .codeWr   (codeWr),
    .toneEn   (toneEn),
    .burstEn  (burstEn),
    .cpMode   (cpMode),
    .strb     (strb),
    .codeLatch(codeLatch),
    .txReady  (txReady)
  );

  dtmf_datapath #(
    .SAMPLE_W(SAMPLE_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .codeLatch (codeLatch),
    .singleTone(singleTone),
    .colSel    (colSel),
    .sampleOut (sampleOut)
  );

endmodule

// File: rtl/dtmf_burst_gen_chk.sv
module dtmf_burst_gen_chk
  import dtmf_pkg::*;
#(
  parameter int SAMPLE_W = 10
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       toneEn,
  input logic                       burstEn,
  input logic                       singleTone,
  input logic                       colSel,
  input logic signed [SAMPLE_W-1:0] sampleOut,
  input logic                       txReady,
  input strobes_t                   strb,
  input logic [3:0]                 codeLatch
);

  p_reset_quiet_r10: assert property (@(posedge clk)
    !rstN |=> (sampleOut == '0 && !txReady));

  p_silent_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    !toneEn |=> (sampleOut == '0));

  p_no_ready_cont_r6: assert property (@(posedge clk) disable iff (!rstN)
    !burstEn |=> !txReady);

  p_ready_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    txReady |=> !txReady);

  p_ready_after_pause_r7: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> $past(strb.busy));

  p_code_held_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.busy |=> $stable(codeLatch));

  p_row_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (singleTone && !colSel) |=> ($signed(sampleOut) <= 100 && $signed(sampleOut) >= -100));

  p_col_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    singleTone |=> ($signed(sampleOut) <= 125 && $signed(sampleOut) >= -125));

  p_sum_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    $signed(sampleOut) <= 225 && $signed(sampleOut) >= -225);

endmodule

bind dtmf_burst_gen dtmf_burst_gen_chk #(.SAMPLE_W(SAMPLE_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .toneEn    (toneEn),
  .burstEn   (burstEn),
  .singleTone(singleTone),
  .colSel    (colSel),
  .sampleOut (sampleOut),
  .txReady   (txReady),
  .strb      (strb),
  .codeLatch (codeLatch)
);

// File: tb/test_dtmf_burst_gen.sv
`timescale 1ns/1ps
module test_dtmf_burst_gen;

  localparam int TD  = 10;
  localparam int BT  = 30;
  localparam int LEN = TD * BT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] codeIn = 4'd0;
  logic codeWr = 1'b0;
  logic toneEn = 1'b0;
  logic burstEn = 1'b0;
  logic cpMode = 1'b0;
  logic singleTone = 1'b0;
  logic colSel = 1'b0;
  logic signed [9:0] sampleOut;
  logic txReady;

  int cyc = 0;
  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  typedef struct {
    int    at;
    string req;
  } readyItem_t;
  readyItem_t expQ[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dtmf_burst_gen #(
    .TICK_DIV   (TD),
    .BURST_TICKS(BT),
    .SAMPLE_W   (10)
  ) i_dtmf_burst_gen (
    .clk       (clk),
    .rstN      (rstN),
    .codeIn    (codeIn),
    .codeWr    (codeWr),
    .toneEn    (toneEn),
    .burstEn   (burstEn),
    .cpMode    (cpMode),
    .singleTone(singleTone),
    .colSel    (colSel),
    .sampleOut (sampleOut),
    .txReady   (txReady)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops expected ready events and compares their cycle
  always @(negedge clk) begin
    readyItem_t it;
    if (rstN && txReady) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6,R9", "unexpected ready at cycle", cyc, -1);
      end else begin
        it = expQ.pop_front();
        check(cyc == it.at, it.req, "ready cycle", cyc, it.at);
      end
    end
  end

  task automatic writeCode(input logic [3:0] c, output int cw);
    @(negedge clk);
    codeIn = c;
    codeWr = 1'b1;
    cw     = cyc;
    @(negedge clk);
    codeWr = 1'b0;
  endtask

  task automatic measureTone(output int per, output int mx, output int mn);
    int prev;
    int t0;
    int n;
    per = -1; mx = -1000; mn = 1000;
    prev = sampleOut;
    n = 0;
    t0 = -1;
    while (t0 < 0 && n < 20000) begin
      @(negedge clk);
      n++;
      if (prev <= 0 && sampleOut > 0) t0 = cyc;
      prev = sampleOut;
    end
    n = 0;
    while (per < 0 && n < 20000) begin
      @(negedge clk);
      n++;
      if (sampleOut > mx) mx = sampleOut;
      if (sampleOut < mn) mn = sampleOut;
      if (prev <= 0 && sampleOut > 0) per = cyc - t0;
      prev = sampleOut;
    end
  endtask

  task automatic toneCase(input logic [3:0] code, input bit col, input int expPer,
                          input string req);
    int cw;
    int per;
    int mx;
    int mn;
    int pk;
    colSel = col;
    writeCode(code, cw);
    measureTone(per, mx, mn);
    pk = col ? 125 : 100;
    check(per == expPer, req, "tone period", per, expPer);
    check(mx == pk, "R2,R3", "positive peak", mx, pk);
    check(mn == -pk, "R2,R3", "negative peak", mn, -pk);
  endtask

  task automatic scanBurst(input int cw, input int len, input int midAt,
                           output int lateNz, output int pauseNz);
    lateNz = 0;
    pauseNz = 0;
    while (cyc < cw + 2 * len + 4) begin
      @(negedge clk);
      codeWr = (midAt > 0 && cyc == cw + midAt);
      if (codeWr) codeIn = 4'd3;
      if (cyc >= cw + len / 2 && cyc <= cw + len && sampleOut != 0) lateNz++;
      if (cyc >= cw + len + 3 && cyc <= cw + 2 * len && sampleOut != 0) pauseNz++;
    end
    codeWr = 1'b0;
  endtask

  task automatic printSummary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    int cw;
    int mx;
    int mn;
    int nz;
    int lateNz;
    int pauseNz;

    repeat (5) @(negedge clk);
    check(sampleOut == 0, "R10", "sample in reset", sampleOut, 0);
    check(txReady == 1'b0, "R10", "ready in reset", txReady, 0);
    rstN = 1'b1;
    @(negedge clk);

    // single tones, continuous mode (R1 decode, R2 period, R3 selection)
    singleTone = 1'b1;
    toneEn     = 1'b1;
    toneCase(4'd5,  1'b0, 4640, "R1");
    toneCase(4'd5,  1'b1, 2688, "R1");
    toneCase(4'd0,  1'b0, 3808, "R1");
    toneCase(4'd0,  1'b1, 2208, "R1");
    toneCase(4'd11, 1'b1, 2976, "R1");
    toneCase(4'd13, 1'b0, 5120, "R1");
    toneCase(4'd12, 1'b1, 2432, "R1");
    toneCase(4'd9,  1'b0, 4192, "R1");

    // dual tone sum (R4)
    singleTone = 1'b0;
    writeCode(4'd5, cw);
    mx = -1000; mn = 1000;
    repeat (10000) begin
      @(negedge clk);
      if (sampleOut > mx) mx = sampleOut;
      if (sampleOut < mn) mn = sampleOut;
    end
    check(mx > 125 && mx <= 225, "R4", "dual positive peak", mx, 225);
    check(mn < -125 && mn >= -225, "R4", "dual negative peak", mn, -225);

    // enable off (R5)
    @(negedge clk);
    toneEn = 1'b0;
    @(negedge clk);
    nz = 0;
    repeat (300) begin
      @(negedge clk);
      if (sampleOut != 0) nz++;
    end
    check(nz == 0, "R5", "nonzero samples while disabled", nz, 0);

    // continuous play, no ready (R6)
    toneEn = 1'b1;
    @(negedge clk);
    nz = 0;
    repeat (2000) begin
      @(negedge clk);
      if (sampleOut != 0) nz++;
    end
    check(nz > 1000, "R6", "nonzero samples in continuous play", nz, 1000);
    check(expQ.size() == 0, "R6", "pending ready events", expQ.size(), 0);

    // burst mode, normal length, with an ignored write mid-burst (R7, R9)
    burstEn = 1'b1;
    repeat (3) @(negedge clk);
    writeCode(4'd7, cw);
    expQ.push_back('{at: cw + 1 + 2 * LEN, req: "R7"});
    scanBurst(cw, LEN, 100, lateNz, pauseNz);
    check(lateNz > 0, "R7", "nonzero samples late in burst", lateNz, 1);
    check(pauseNz == 0, "R7", "nonzero samples in pause", pauseNz, 0);
    check(expQ.size() == 0, "R7", "ready events still pending", expQ.size(), 0);
    nz = 0;
    repeat (800) begin
      @(negedge clk);
      if (sampleOut != 0) nz++;
    end
    check(nz == 0, "R9", "tone after ignored write", nz, 0);

    // call-progress doubling with an ignored write in the pause (R8, R9)
    cpMode = 1'b1;
    writeCode(4'd2, cw);
    expQ.push_back('{at: cw + 1 + 4 * LEN, req: "R8"});
    scanBurst(cw, 2 * LEN, 2 * LEN + 100, lateNz, pauseNz);
    check(lateNz > 0, "R8", "tone beyond normal burst length", lateNz, 1);
    check(pauseNz == 0, "R8", "nonzero samples in long pause", pauseNz, 0);
    check(expQ.size() == 0, "R8", "ready events still pending", expQ.size(), 0);
    nz = 0;
    repeat (1500) begin
      @(negedge clk);
      if (sampleOut != 0) nz++;
    end
    check(nz == 0, "R9", "tone after write in pause", nz, 0);

    finished = 1'b1;
    printSummary();
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL R7 watchdog: actual cycle %0d expected completion", cyc);
      printSummary();
      $finish;
    end
  end

endmodule